// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block owns the 64-bit control image of a clock-synthesis PLL and walks it through a safe reprogramming sequence whenever a start pulse arrives with a new set of divider values. The output is first switched to the bypass path and disconnected. The PLL is then powered down and its parameter latch opened. The three divider fields are written and the latch closed, and the PLL is powered back up. After a settling delay the block polls the lock input. Once lock is seen, or the poll budget is used up, it reconnects the output and leaves bypass.

Each step rewrites one field of the image and leaves every other bit as it was. Each step takes one clock cycle. The settling delay is counted in cycles, derived from a clock-frequency parameter in MHz and a delay parameter in microseconds. At the end the block pulses an acknowledge. It reports how many polls were used and whether the poll budget ran out. The divider fields of the image are always available on dedicated readback outputs.

Top module: `pll_reprog_seq`

## Requirements
- R1: During and after reset the image holds bypass (bit 44) and power-down (bit 45) set and every other bit zero. `reqAck`, `pollsUsed` and `lockTimeout` are zero.
- R2: A `startReq` pulse is accepted only when the block is idle. The divider inputs are captured in the accepting cycle. Pulses that arrive during a sequence are ignored: they produce no extra acknowledge and do not alter the programmed values.
- R3: The clock edge after acceptance begins one image change per cycle, in this order: set bypass (bit 44), clear output select (bit 40), set power-down (bit 45), set the parameter trigger (bit 43), write the dividers, clear the trigger, clear power-down.
- R4: Each step changes only its own field. The divider write places the output divider in bits 6:0, the multiplier in bits 29:21 and the input divider in bits 38:32.
- R5: After power-down is cleared, the block waits CLK_MHZ*SETTLE_US cycles (100 by default) before the first lock poll.
- R6: Polling samples `lockIn` once per cycle and stops at the first poll that sees 1. `pollsUsed` then equals the number of polls made, including that one, and `lockTimeout` is 0.
- R7: If lock is not seen within MAX_POLLS polls (2000 by default), polling stops anyway and the sequence continues. `pollsUsed` equals MAX_POLLS and `lockTimeout` is 1.
- R8: The cycle after polling ends, output select (bit 40) is set. The next cycle clears bypass (bit 44), and `reqAck` is high for exactly that one cycle.
- R9: `rbDivOut`, `rbMult` and `rbDivRef` always equal image bits 6:0, 29:21 and 38:32.
- R10: Image bit 39 shows the value of `lockIn` from one clock edge earlier.
- R11: All image bits other than 6:0, 29:21, 38:32, 39, 40, 43, 44 and 45 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to reprogram |
| divOutIn | input | 7 | New output divider |
| multIn | input | 9 | New feedback multiplier |
| divRefIn | input | 7 | New input divider |
| lockIn | input | 1 | Lock indicator from the PLL |
| reqAck | output | 1 | One-cycle completion pulse |
| regImage | output | 64 | PLL control register image |
| rbDivOut | output | 7 | Programmed output divider |
| rbMult | output | 9 | Programmed multiplier |
| rbDivRef | output | 7 | Programmed input divider |
| pollsUsed | output | clog2(MAX_POLLS+1) (11) | Lock polls made in the last sequence |
| lockTimeout | output | 1 | Last sequence ended without lock |

## Verification
The control state cannot be read directly, so a wrong state shows up on the image. A step skipped or out of order changes the image in the wrong cycle, and a check on the very next clock sees it. A settle or poll counter that is off by one moves the rise of output select by that many cycles, and the bench compares the exact cycle of that rise. A divider captured from the wrong cycle, or a latched request arriving mid-sequence, only shows when the sequence ends, in the final image, the readback values and the acknowledge count.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  // Field placement inside the 64-bit control image
  localparam int DIVOUT_LSB = 0;
  localparam int DIVOUT_W   = 7;
  localparam int MULT_LSB   = 21;
  localparam int MULT_W     = 9;
  localparam int DIVREF_LSB = 32;
  localparam int DIVREF_W   = 7;
  localparam int LOCK_BIT   = 39;
  localparam int OUTSEL_BIT = 40;
  localparam int TRIG_BIT   = 43;
  localparam int BYPASS_BIT = 44;
  localparam int PWRDN_BIT  = 45;

  localparam logic [63:0] RESET_IMAGE = (64'd1 << BYPASS_BIT) | (64'd1 << PWRDN_BIT);

  // Per-cycle step strobes issued by the control FSM
  typedef struct packed {
    logic capture;
    logic setBypass;
    logic clrOutSel;
    logic setPwrDn;
    logic setTrig;
    logic loadDiv;
    logic clrTrig;
    logic clrPwrDn;
    logic setOutSel;
    logic clrBypass;
  } stepStrobes_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BYPASS,
    ST_OUTOFF,
    ST_PWRDN,
    ST_TRIG,
    ST_LOAD,
    ST_UNTRIG,
    ST_PWRUP,
    ST_SETTLE,
    ST_POLL,
    ST_OUTON,
    ST_UNBYPASS,
    ST_DONE
  } seqState_t;

endpackage

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
  import pllseq_pkg::*;
#(
  parameter int SETTLE_CYC = 100,
  parameter int MAX_POLLS  = 2000,
  localparam int SW = $clog2(SETTLE_CYC + 1),
  localparam int PW = $clog2(MAX_POLLS + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         lockIn,
  output stepStrobes_t strobes,
  output logic         ackOut,
  output logic [PW-1:0] pollCnt,
  output logic         timeoutFlag
);

  seqState_t state, nextState;
  logic [SW-1:0] settleCnt;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:     if (startReq) nextState = ST_BYPASS;
      ST_BYPASS:   nextState = ST_OUTOFF;
      ST_OUTOFF:   nextState = ST_PWRDN;
      ST_PWRDN:    nextState = ST_TRIG;
      ST_TRIG:     nextState = ST_LOAD;
      ST_LOAD:     nextState = ST_UNTRIG;
      ST_UNTRIG:   nextState = ST_PWRUP;
      ST_PWRUP:    nextState = ST_SETTLE;
      ST_SETTLE:   if (settleCnt == SW'(SETTLE_CYC - 1)) nextState = ST_POLL;
      ST_POLL:     if (lockIn || (pollCnt == PW'(MAX_POLLS - 1))) nextState = ST_OUTON;
      ST_OUTON:    nextState = ST_UNBYPASS;
      ST_UNBYPASS: nextState = ST_DONE;
      ST_DONE:     nextState = ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes           = '0;
    strobes.capture   = (state == ST_IDLE) && startReq;
    strobes.setBypass = (state == ST_BYPASS);
    strobes.clrOutSel = (state == ST_OUTOFF);
    strobes.setPwrDn  = (state == ST_PWRDN);
    strobes.setTrig   = (state == ST_TRIG);
    strobes.loadDiv   = (state == ST_LOAD);
    strobes.clrTrig   = (state == ST_UNTRIG);
    strobes.clrPwrDn  = (state == ST_PWRUP);
    strobes.setOutSel = (state == ST_OUTON);
    strobes.clrBypass = (state == ST_UNBYPASS);
  end

  assign ackOut = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      settleCnt   <= '0;
      pollCnt     <= '0;
      timeoutFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_SETTLE) settleCnt <= settleCnt + 1'b1;
      else                    settleCnt <= '0;
      if (strobes.capture) begin
        pollCnt     <= '0;
        timeoutFlag <= 1'b0;
      end else if (state == ST_POLL) begin
        pollCnt <= pollCnt + 1'b1;
        if (!lockIn && (pollCnt == PW'(MAX_POLLS - 1))) timeoutFlag <= 1'b1;
      end
    end
  end

  // Acknowledge lasts a single cycle
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> !ackOut);

  // Poll count never exceeds its budget
  p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= PW'(MAX_POLLS));

  // Timeout only raised after a full budget of polls
  p_timeout_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> (pollCnt == PW'(MAX_POLLS)));

  // First poll only after the full settle count
  p_settle_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_POLL) && ($past(state) == ST_SETTLE)) |-> ($past(settleCnt) == SW'(SETTLE_CYC - 1)));

  // At most one step per cycle
  p_one_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

endmodule

// File: rtl/pllseq_datapath.sv
module pllseq_datapath
  import pllseq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  stepStrobes_t        strobes,
  input  logic [DIVOUT_W-1:0] divOutIn,
  input  logic [MULT_W-1:0]   multIn,
  input  logic [DIVREF_W-1:0] divRefIn,
  input  logic                lockIn,
  output logic [63:0]         regImage,
  output logic [DIVOUT_W-1:0] rbDivOut,
  output logic [MULT_W-1:0]   rbMult,
  output logic [DIVREF_W-1:0] rbDivRef
);

  logic [DIVOUT_W-1:0] pendDivOut;
  logic [MULT_W-1:0]   pendMult;
  logic [DIVREF_W-1:0] pendDivRef;
  logic [63:0]         nextImage;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendDivOut <= '0;
      pendMult   <= '0;
      pendDivRef <= '0;
    end else if (strobes.capture) begin
      pendDivOut <= divOutIn;
      pendMult   <= multIn;
      pendDivRef <= divRefIn;
    end
  end

  // Read-modify-write: each strobe touches only its own field
  always_comb begin
    nextImage           = regImage;
    nextImage[LOCK_BIT] = lockIn;
    if (strobes.setBypass) nextImage[BYPASS_BIT] = 1'b1;
    if (strobes.clrOutSel) nextImage[OUTSEL_BIT] = 1'b0;
    if (strobes.setPwrDn)  nextImage[PWRDN_BIT]  = 1'b1;
    if (strobes.setTrig)   nextImage[TRIG_BIT]   = 1'b1;
    if (strobes.loadDiv) begin
      nextImage[DIVOUT_LSB +: DIVOUT_W] = pendDivOut;
      nextImage[MULT_LSB +: MULT_W]     = pendMult;
      nextImage[DIVREF_LSB +: DIVREF_W] = pendDivRef;
    end
    if (strobes.clrTrig)   nextImage[TRIG_BIT]   = 1'b0;
    if (strobes.clrPwrDn)  nextImage[PWRDN_BIT]  = 1'b0;
    if (strobes.setOutSel) nextImage[OUTSEL_BIT] = 1'b1;
    if (strobes.clrBypass) nextImage[BYPASS_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) regImage <= RESET_IMAGE;
    else       regImage <= nextImage;
  end

  assign rbDivOut = regImage[DIVOUT_LSB +: DIVOUT_W];
  assign rbMult   = regImage[MULT_LSB +: MULT_W];
  assign rbDivRef = regImage[DIVREF_LSB +: DIVREF_W];

  // Power-down is only raised while the output is bypassed
  p_pd_needs_bypass_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regImage[PWRDN_BIT]) |-> regImage[BYPASS_BIT]);

  // Parameter trigger only opened while powered down
  p_trig_needs_pd_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regImage[TRIG_BIT]) |-> regImage[PWRDN_BIT]);

  // Divider fields only move while the trigger is open
  p_div_under_trig_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({regImage[DIVOUT_LSB +: DIVOUT_W], regImage[MULT_LSB +: MULT_W],
              regImage[DIVREF_LSB +: DIVREF_W]}) |-> regImage[TRIG_BIT]);

  // Output reconnected only when powered and still bypassed
  p_outsel_safe_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regImage[OUTSEL_BIT]) |-> (!regImage[PWRDN_BIT] && regImage[BYPASS_BIT]));

  // Lock bit follows the lock input one edge later
  p_lock_mirror_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (regImage[LOCK_BIT] == $past(lockIn)));

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pllseq_pkg::*;
#(
  parameter int CLK_MHZ   = 50,
  parameter int SETTLE_US = 2,
  parameter int MAX_POLLS = 2000,
  localparam int SETTLE_CYC = CLK_MHZ * SETTLE_US,
  localparam int PW = $clog2(MAX_POLLS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic [DIVOUT_W-1:0] divOutIn,
  input  logic [MULT_W-1:0]   multIn,
  input  logic [DIVREF_W-1:0] divRefIn,
  input  logic                lockIn,
  output logic                reqAck,
  output logic [63:0]         regImage,
  output logic [DIVOUT_W-1:0] rbDivOut,
  output logic [MULT_W-1:0]   rbMult,
  output logic [DIVREF_W-1:0] rbDivRef,
  output logic [PW-1:0]       pollsUsed,
  output logic                lockTimeout
);

  stepStrobes_t strobes;

  pllseq_ctrl #(
    .SETTLE_CYC (SETTLE_CYC),
    .MAX_POLLS  (MAX_POLLS)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .lockIn      (lockIn),
    .strobes     (strobes),
    .ackOut      (reqAck),
    .pollCnt     (pollsUsed),
    .timeoutFlag (lockTimeout)
  );

  pllseq_datapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .divOutIn (divOutIn),
    .multIn   (multIn),
    .divRefIn (divRefIn),
    .lockIn   (lockIn),
    .regImage (regImage),
    .rbDivOut (rbDivOut),
    .rbMult   (rbMult),
    .rbDivRef (rbDivRef)
  );

endmodule

// File: tb/tb_pll_reprog_seq.sv
module tb_pll_reprog_seq;

  localparam int S    = 100;
  localparam int MAXP = 2000;
  localparam logic [63:0] B39 = 64'd1 << 39;
  localparam logic [63:0] B40 = 64'd1 << 40;
  localparam logic [63:0] B43 = 64'd1 << 43;
  localparam logic [63:0] B44 = 64'd1 << 44;
  localparam logic [63:0] B45 = 64'd1 << 45;
  localparam logic [63:0] USED = 64'h000039FF_3FE0007F;
  localparam logic [63:0] RST  = B44 | B45;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [6:0] divOutIn = '0;
  logic [8:0] multIn = '0;
  logic [6:0] divRefIn = '0;
  logic lockIn = 1'b0;
  logic reqAck;
  logic [63:0] regImage;
  logic [6:0] rbDivOut;
  logic [8:0] rbMult;
  logic [6:0] rbDivRef;
  logic [10:0] pollsUsed;
  logic lockTimeout;

  typedef struct {
    logic [63:0] img;
    int polls;
    bit tmo;
  } expItem_t;

  expItem_t scoreQ[$];
  int checks = 0;
  int failures = 0;
  int acksSeen = 0;
  bit finished = 1'b0;
  logic [63:0] mdl;

  always #10 clk = ~clk;

  pll_reprog_seq dut (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .divOutIn(divOutIn), .multIn(multIn), .divRefIn(divRefIn),
    .lockIn(lockIn), .reqAck(reqAck), .regImage(regImage),
    .rbDivOut(rbDivOut), .rbMult(rbMult), .rbDivRef(rbDivRef),
    .pollsUsed(pollsUsed), .lockTimeout(lockTimeout)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected results as acknowledges appear
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && reqAck) begin
        acksSeen++;
        if (scoreQ.size() == 0) begin
          chk(1'b0, "R2 unexpected ack", 64'd1, 64'd0);
        end else begin
          expItem_t e;
          e = scoreQ.pop_front();
          chk(regImage === e.img, "R8 final image", regImage, e.img);
          chk(pollsUsed === 11'(e.polls), "R6 pollsUsed", 64'(pollsUsed), 64'(e.polls));
          chk(lockTimeout === e.tmo, "R7 timeout flag", 64'(lockTimeout), 64'(e.tmo));
          chk({rbDivRef, rbMult, rbDivOut} === {e.img[38:32], e.img[29:21], e.img[6:0]},
              "R9 readback", 64'({rbDivRef, rbMult, rbDivOut}),
              64'({e.img[38:32], e.img[29:21], e.img[6:0]}));
        end
      end
    end
  end

  // Driver: runs one sequence, checks step images, pushes expected result
  task automatic runSeq(input logic [6:0] dO, input logic [8:0] ml, input logic [6:0] dR,
                        input int lockAfter, input bit midReq);
    logic [63:0] st [1:7];
    expItem_t e;
    int cnt;
    int polls;
    int rise;
    lockIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    mdl[39] = 1'b0;
    st[1] = mdl | B44;
    st[2] = st[1] & ~B40;
    st[3] = st[2] | B45;
    st[4] = st[3] | B43;
    st[5] = st[4];
    st[5][6:0] = dO;
    st[5][29:21] = ml;
    st[5][38:32] = dR;
    st[6] = st[5] & ~B43;
    st[7] = st[6] & ~B45;
    polls = (lockAfter >= 0) ? lockAfter + 1 : MAXP;
    rise = 8 + S + polls;
    e.img = (st[7] | B40) & ~B44;
    if (lockAfter >= 0) e.img = e.img | B39;
    e.polls = polls;
    e.tmo = (lockAfter < 0);
    scoreQ.push_back(e);
    divOutIn = dO; multIn = ml; divRefIn = dR;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    divOutIn = ~dO; multIn = ~ml; divRefIn = ~dR;  // R2: later input values must not matter
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      chk(regImage === st[i], $sformatf("R3 R4 step %0d image", i), regImage, st[i]);
      chk((regImage & ~USED) == 64'd0, "R11 reserved zero", regImage & ~USED, 64'd0);
      if (midReq && i == 3) startReq = 1'b1;
      if (midReq && i == 4) startReq = 1'b0;
    end
    cnt = 7;
    while (regImage[40] !== 1'b1 && cnt < 8 + S + MAXP + 10) begin
      @(negedge clk);
      cnt++;
      if (lockAfter >= 0 && cnt == 7 + S + lockAfter) lockIn = 1'b1;
    end
    chk(cnt == rise, "R5 R6 R7 output-select rise cycle", 64'(cnt), 64'(rise));
    chk(regImage === (st[7] | B40 | (lockAfter >= 0 ? B39 : 64'd0)), "R8 output-select step",
        regImage, st[7] | B40 | (lockAfter >= 0 ? B39 : 64'd0));
    @(negedge clk);
    chk(reqAck === 1'b1, "R8 ack with unbypass", 64'(reqAck), 64'd1);
    @(negedge clk);
    chk(reqAck === 1'b0, "R8 ack single cycle", 64'(reqAck), 64'd0);
    mdl = e.img;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(regImage === RST, "R1 reset image", regImage, RST);
    chk(reqAck === 1'b0 && pollsUsed === 11'd0 && lockTimeout === 1'b0, "R1 reset outputs",
        64'({reqAck, pollsUsed, lockTimeout}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(regImage === RST, "R1 image after reset", regImage, RST);
    mdl = RST;
    runSeq(7'd11, 9'd49, 7'd3, 0, 1'b0);
    runSeq(7'd85, 9'd107, 7'd5, 5, 1'b1);
    runSeq(7'd20, 9'd39, 7'd3, -1, 1'b0);
    runSeq(7'd127, 9'd511, 7'd127, 2, 1'b0);
    repeat (30) @(negedge clk);
    chk(acksSeen == 4, "R2 ack count", 64'(acksSeen), 64'd4);
    chk(scoreQ.size() == 0, "R2 scoreboard drained", 64'(scoreQ.size()), 64'd0);
    lockIn = 1'b0;
    @(negedge clk);
    lockIn = 1'b1;
    chk(regImage[39] === 1'b0, "R10 lock bit before edge", 64'(regImage[39]), 64'd0);
    @(negedge clk);
    chk(regImage === (mdl | B39), "R10 lock bit follows", regImage, mdl | B39);
    lockIn = 1'b0;
    @(negedge clk);
    chk(regImage === (mdl & ~B39), "R10 lock bit clears", regImage, mdl & ~B39);
    chk((regImage & ~USED) == 64'd0, "R11 reserved zero idle", regImage & ~USED, 64'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule